// File: doc/BRIEF.md
# Per-Pin Function Multiplexer with Signal Overrides

This block sits between a bank of general-purpose pads and the peripherals that share them. Each pin holds a configuration word: a 4-bit function select and three 2-bit override fields. The function select routes one peripheral channel's output value and output enable to the pad. The pad's input value goes back to that same channel. Each override field can pass, invert, force low or force high its own signal. The three fields act on the outgoing value, the outgoing enable and the incoming value, independently of one another.

Peripheral channels follow a fixed, computed table. With `NCH` lanes per function, function code `f` on pin `p` uses channel `f*NCH + (p mod NCH)`. Pins that are `NCH` apart and select the same function therefore share a channel. When several pins share a channel, that peripheral input sees the OR of all of them.

A single-word write port loads the configuration of one pin per clock. The routing is combinational from the configuration registers. A write therefore shows at the pads and the peripheral inputs in the cycle right after the clock edge that captures it. Software normally brings a pin into use by selecting function code 5 with its output value and enable cleared.

Top module: `pin_func_mux`

## Requirements
- R1: After synchronous reset every pin has function code 15 and all override fields at 0, so `pad_out`, `pad_oe` and `periph_in` are all zero whatever the inputs are.
- R2: A pin with function code f in 0..NFUNC-1 (default 0..9) drives `pad_out` and `pad_oe` from channel f*NCH + (pin mod NCH) of `periph_out` and `periph_oe`, before any override is applied.
- R3: A function code of NFUNC or above (10..15 by default; 15 is the reset "no function" code) gives a selected output value and enable of 0 before overrides, and the pin feeds no peripheral input.
- R4: Each bit of `periph_in` is the OR of the input values of all pins whose selection maps to that channel. A channel that no pin selects reads 0.
- R5: The output-value override (`wr_data[5:4]`) takes the encoding 0 = pass, 1 = invert, 2 = force 0, 3 = force 1, and is applied to the selected output value.
- R6: The output-enable override (`wr_data[3:2]`) uses the same encoding on the selected enable. Code 2 disables the output and code 3 enables it.
- R7: The input override (`wr_data[1:0]`) uses the same encoding on the pad input value. It acts before the value is ORed into the peripheral input.
- R8: When `wr_en` is high at a clock edge, pin `wr_pin` takes `wr_data`, with the function code in bits [9:6]. The new setting shows at the outputs from the cycle after that edge.
- R9: A write whose `wr_pin` is NPINS or above changes no pin's configuration.
- R10: A write changes only the addressed pin. All other pins keep their configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_pin | input | PIN_W (5) | Index of the pin to write |
| wr_data | input | 10 | Configuration word {fsel[3:0], out_ov[1:0], oe_ov[1:0], in_ov[1:0]} |
| pad_in | input | NPINS (30) | Value sampled at each pad |
| pad_out | output | NPINS (30) | Output value to each pad |
| pad_oe | output | NPINS (30) | Output enable to each pad |
| periph_out | input | NCHAN (80) | Output value from each peripheral channel |
| periph_oe | input | NCHAN (80) | Output enable from each peripheral channel |
| periph_in | output | NCHAN (80) | Input value delivered to each peripheral channel |

## Verification
The configuration registers are the only state in this block, and every path from them to the ports is combinational. A corrupted function code or override field therefore shows at `pad_out`, `pad_oe` or `periph_in` in the first cycle after the bad write, as long as the inputs exercise that pin. The bench drives fresh random pad and peripheral values on every clock. This means a wrong field cannot hide for long behind a quiet input. A lost or misdirected write shows up as a mismatch on the addressed pin, or on some other pin, from the next cycle onward.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    localparam int unsigned FSEL_W = 4;
    localparam int unsigned OVR_W  = 2;
    localparam int unsigned CFG_W  = FSEL_W + 3 * OVR_W;

    localparam logic [FSEL_W-1:0] FSEL_NONE = 4'hF;

    typedef enum logic [OVR_W-1:0] {
        OVR_PASS = 2'd0,
        OVR_INV  = 2'd1,
        OVR_LOW  = 2'd2,
        OVR_HIGH = 2'd3
    } ovr_e;

    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
        ovr_e              out_ov;
        ovr_e              oe_ov;
        ovr_e              in_ov;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{
        fsel:   FSEL_NONE,
        out_ov: OVR_PASS,
        oe_ov:  OVR_PASS,
        in_ov:  OVR_PASS
    };

    typedef struct packed {
        logic val;
        logic en;
    } drive_t;

    function automatic logic apply_ovr(input ovr_e mode, input logic sig);
        logic r;
        case (mode)
            OVR_PASS: r = sig;
            OVR_INV:  r = ~sig;
            OVR_LOW:  r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfm_cfg_regs.sv
module pfm_cfg_regs
    import pfm_pkg::*;
#(
    parameter int unsigned NPINS = 30,
    parameter int unsigned PIN_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [PIN_W-1:0]        wr_pin,
    input  pin_cfg_t                wr_cfg,
    output pin_cfg_t [NPINS-1:0]    cfg_q
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic hit;
        assign hit = wr_en && (wr_pin == PIN_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[p] <= CFG_RESET;
            end else if (hit) begin
                cfg_q[p] <= wr_cfg;
            end
        end
    end

endmodule

// File: rtl/pfm_pin_path.sv
module pfm_pin_path
    import pfm_pkg::*;
#(
    parameter int unsigned PIN_IDX = 0,
    parameter int unsigned NFUNC   = 10,
    parameter int unsigned NCH     = 8,
    parameter int unsigned NCHAN   = NFUNC * NCH,
    parameter int unsigned CHAN_W  = $clog2(NCHAN)
) (
    input  pin_cfg_t            cfg,
    input  logic [NCHAN-1:0]    periph_out,
    input  logic [NCHAN-1:0]    periph_oe,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                sel_valid,
    output logic [CHAN_W-1:0]   sel_chan,
    output logic                in_val
);

    localparam int unsigned       LANE    = PIN_IDX % NCH;
    localparam logic [FSEL_W-1:0] NFUNC_L = FSEL_W'(NFUNC);

    drive_t sel_drv;

    // Channel index from the computed slot table.
    assign sel_valid = (cfg.fsel < NFUNC_L);
    assign sel_chan  = CHAN_W'(cfg.fsel) * CHAN_W'(NCH) + CHAN_W'(LANE);

    always_comb begin
        sel_drv = '{val: 1'b0, en: 1'b0};
        if (sel_valid) begin
            sel_drv.val = periph_out[sel_chan];
            sel_drv.en  = periph_oe[sel_chan];
        end
    end

    assign pad_out = apply_ovr(cfg.out_ov, sel_drv.val);
    assign pad_oe  = apply_ovr(cfg.oe_ov,  sel_drv.en);
    assign in_val  = apply_ovr(cfg.in_ov,  pad_in);

endmodule

// File: rtl/pfm_in_fanout.sv
module pfm_in_fanout #(
    parameter int unsigned NPINS  = 30,
    parameter int unsigned NCHAN  = 80,
    parameter int unsigned CHAN_W = $clog2(NCHAN)
) (
    input  logic [NPINS-1:0]              sel_valid,
    input  logic [NPINS-1:0][CHAN_W-1:0]  sel_chan,
    input  logic [NPINS-1:0]              in_val,
    output logic [NCHAN-1:0]              periph_in
);

    // Every channel collects the OR of all pins that currently map onto it.
    always_comb begin
        periph_in = '0;
        for (int c = 0; c < NCHAN; c++) begin
            for (int p = 0; p < NPINS; p++) begin
                if (sel_valid[p] && (sel_chan[p] == CHAN_W'(c))) begin
                    periph_in[c] = periph_in[c] | in_val[p];
                end
            end
        end
    end

endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
    import pfm_pkg::*;
#(
    parameter int unsigned NPINS  = 30,
    parameter int unsigned NFUNC  = 10,
    parameter int unsigned NCH    = 8,
    parameter int unsigned PIN_W  = $clog2(NPINS),
    parameter int unsigned NCHAN  = NFUNC * NCH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [PIN_W-1:0]    wr_pin,
    input  logic [CFG_W-1:0]    wr_data,
    input  logic [NPINS-1:0]    pad_in,
    output logic [NPINS-1:0]    pad_out,
    output logic [NPINS-1:0]    pad_oe,
    input  logic [NCHAN-1:0]    periph_out,
    input  logic [NCHAN-1:0]    periph_oe,
    output logic [NCHAN-1:0]    periph_in
);

    localparam int unsigned CHAN_W = $clog2(NCHAN);

    pin_cfg_t [NPINS-1:0]             cfg_q;
    logic     [NPINS-1:0]             sel_valid;
    logic     [NPINS-1:0][CHAN_W-1:0] sel_chan;
    logic     [NPINS-1:0]             in_val;

    pfm_cfg_regs #(
        .NPINS (NPINS),
        .PIN_W (PIN_W)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_pin (wr_pin),
        .wr_cfg (pin_cfg_t'(wr_data)),
        .cfg_q  (cfg_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_path
        pfm_pin_path #(
            .PIN_IDX (p),
            .NFUNC   (NFUNC),
            .NCH     (NCH),
            .NCHAN   (NCHAN),
            .CHAN_W  (CHAN_W)
        ) i_path (
            .cfg        (cfg_q[p]),
            .periph_out (periph_out),
            .periph_oe  (periph_oe),
            .pad_in     (pad_in[p]),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p]),
            .sel_valid  (sel_valid[p]),
            .sel_chan   (sel_chan[p]),
            .in_val     (in_val[p])
        );
    end

    pfm_in_fanout #(
        .NPINS  (NPINS),
        .NCHAN  (NCHAN),
        .CHAN_W (CHAN_W)
    ) i_fanout (
        .sel_valid (sel_valid),
        .sel_chan  (sel_chan),
        .in_val    (in_val),
        .periph_in (periph_in)
    );

endmodule

// File: rtl/pin_func_mux_chk.sv
module pin_func_mux_chk
    import pfm_pkg::*;
#(
    parameter int unsigned NPINS = 30,
    parameter int unsigned NFUNC = 10,
    parameter int unsigned PIN_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [PIN_W-1:0]        wr_pin,
    input  logic [CFG_W-1:0]        wr_data,
    input  pin_cfg_t [NPINS-1:0]    cfg_q,
    input  logic [NPINS-1:0]        pad_out,
    input  logic [NPINS-1:0]        pad_oe
);

    localparam logic [FSEL_W-1:0] NFUNC_L = FSEL_W'(NFUNC);

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        // R8
        cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_pin == PIN_W'(p)) |=> (cfg_q[p] == $past(wr_data)));

        // R9 R10
        cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_pin == PIN_W'(p)) |=> $stable(cfg_q[p]));

        // R6
        oe_force_high_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[p].oe_ov == OVR_HIGH) |-> pad_oe[p]);

        // R6
        oe_force_low_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[p].oe_ov == OVR_LOW) |-> !pad_oe[p]);

        // R5
        out_force_high_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[p].out_ov == OVR_HIGH) |-> pad_out[p]);

        // R5
        out_force_low_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[p].out_ov == OVR_LOW) |-> !pad_out[p]);

        // R3
        null_func_oe_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[p].fsel >= NFUNC_L && cfg_q[p].oe_ov == OVR_PASS) |-> !pad_oe[p]);
    end

endmodule

bind pin_func_mux pin_func_mux_chk #(
    .NPINS (NPINS),
    .NFUNC (NFUNC),
    .PIN_W (PIN_W)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_pin  (wr_pin),
    .wr_data (wr_data),
    .cfg_q   (cfg_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/test_pin_func_mux.sv
module test_pin_func_mux;

    localparam int NPINS  = 30;
    localparam int NFUNC  = 10;
    localparam int NCH    = 8;
    localparam int PIN_W  = 5;
    localparam int NCHAN  = NFUNC * NCH;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [PIN_W-1:0] wr_pin = '0;
    logic [9:0]       wr_data = '0;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out;
    logic [NPINS-1:0] pad_oe;
    logic [NCHAN-1:0] periph_out = '0;
    logic [NCHAN-1:0] periph_oe = '0;
    logic [NCHAN-1:0] periph_in;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // reference configuration
    int m_fsel [NPINS];
    int m_oov  [NPINS];
    int m_eov  [NPINS];
    int m_iov  [NPINS];

    pin_func_mux #(
        .NPINS (NPINS),
        .NFUNC (NFUNC),
        .NCH   (NCH)
    ) i_pin_func_mux (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_pin     (wr_pin),
        .wr_data    (wr_data),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .periph_in  (periph_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic ref_ov(input int mode, input logic s);
        if (mode == 0) return s;
        if (mode == 1) return ~s;
        if (mode == 2) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [NPINS-1:0] e_out = '0;
        logic [NPINS-1:0] e_oe  = '0;
        logic [NCHAN-1:0] e_in  = '0;
        for (int p = 0; p < NPINS; p++) begin
            logic so = 1'b0;
            logic se = 1'b0;
            int   ch = m_fsel[p] * NCH + (p % NCH);
            if (m_fsel[p] < NFUNC) begin
                so = periph_out[ch];
                se = periph_oe[ch];
                if (ref_ov(m_iov[p], pad_in[p])) e_in[ch] = 1'b1;
            end
            e_out[p] = ref_ov(m_oov[p], so);
            e_oe[p]  = ref_ov(m_eov[p], se);
        end
        chk(pad_out == e_out, "R2 R3 R5 pad_out", 128'(pad_out), 128'(e_out));
        chk(pad_oe == e_oe, "R2 R3 R6 pad_oe", 128'(pad_oe), 128'(e_oe));
        chk(periph_in == e_in, "R4 R7 periph_in", 128'(periph_in), 128'(e_in));
    endtask

    task automatic rand_io();
        pad_in     = NPINS'($urandom);
        periph_out = NCHAN'({$urandom, $urandom, $urandom});
        periph_oe  = NCHAN'({$urandom, $urandom, $urandom});
    endtask

    // One clock: drive at the falling edge, compare, then commit the write to the model.
    task automatic step(input logic we, input int pin, input logic [9:0] d, input bit rnd);
        @(negedge clk);
        wr_en   = we;
        wr_pin  = PIN_W'(pin);
        wr_data = d;
        if (rnd) rand_io();
        #1;
        compare_all();
        @(posedge clk);
        if (we && pin < NPINS) begin
            m_fsel[pin] = int'(d[9:6]);
            m_oov[pin]  = int'(d[5:4]);
            m_eov[pin]  = int'(d[3:2]);
            m_iov[pin]  = int'(d[1:0]);
        end
    endtask

    function automatic logic [9:0] cfg(input int f, input int oo, input int eo, input int io);
        return {4'(f), 2'(oo), 2'(eo), 2'(io)};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NPINS; p++) begin
            m_fsel[p] = 15; m_oov[p] = 0; m_eov[p] = 0; m_iov[p] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state with busy inputs
        rand_io();
        periph_oe = '1; periph_out = '1; pad_in = '1;
        #1;
        chk(pad_oe == '0, "R1 pad_oe", 128'(pad_oe), 128'(0));
        chk(pad_out == '0, "R1 pad_out", 128'(pad_out), 128'(0));
        chk(periph_in == '0, "R1 periph_in", 128'(periph_in), 128'(0));

        // R2 R8: pin 3 takes function 5 -> channel 43
        step(1'b1, 3, cfg(5, 0, 0, 0), 1'b0);
        step(1'b0, 0, '0, 1'b0);
        @(negedge clk);
        periph_out = '0; periph_oe = '0; pad_in = '0;
        periph_out[43] = 1'b1; periph_oe[43] = 1'b1; pad_in[3] = 1'b1;
        #1;
        chk(pad_out[3] && pad_oe[3], "R2 routed pin 3", 128'({pad_out[3], pad_oe[3]}), 128'(3));
        chk(periph_in == (NCHAN'(1) << 43), "R4 single selector", 128'(periph_in), 128'(NCHAN'(1) << 43));

        // R4: pin 11 shares channel 43, OR of both
        step(1'b1, 11, cfg(5, 0, 0, 0), 1'b0);
        @(negedge clk);
        pad_in = '0; pad_in[11] = 1'b1;
        #1;
        chk(periph_in[43] == 1'b1, "R4 OR of pins 3 and 11", 128'(periph_in[43]), 128'(1));
        chk(periph_in[42] == 1'b0, "R4 unselected channel", 128'(periph_in[42]), 128'(0));

        // R7: invert input on pin 11 before the OR
        step(1'b1, 11, cfg(5, 0, 0, 1), 1'b0);
        @(negedge clk);
        pad_in = '0; pad_in[11] = 1'b1;
        #1;
        chk(periph_in[43] == 1'b0, "R7 inverted input", 128'(periph_in[43]), 128'(0));

        // R9: writes to pins 30 and 31 are ignored
        step(1'b1, 31, cfg(0, 3, 3, 0), 1'b0);
        step(1'b1, 30, cfg(0, 3, 3, 0), 1'b0);
        @(negedge clk);
        wr_en = 1'b0; periph_oe = '0; periph_out = '0;
        #1;
        chk(pad_oe == '0, "R9 out-of-range write", 128'(pad_oe), 128'(0));

        // R3: reserved code 12 on pin 3 drives nothing
        step(1'b1, 3, cfg(12, 0, 0, 0), 1'b0);
        @(negedge clk);
        periph_oe = '1; periph_out = '1;
        #1;
        chk(!pad_oe[3] && !pad_out[3], "R3 reserved code", 128'({pad_out[3], pad_oe[3]}), 128'(0));
        chk(pad_oe[11], "R10 pin 11 untouched", 128'(pad_oe[11]), 128'(1));

        // R5 R6: forced output on an unselected pin
        step(1'b1, 7, cfg(15, 3, 3, 0), 1'b0);
        @(negedge clk);
        periph_oe = '0; periph_out = '0;
        #1;
        chk(pad_out[7] && pad_oe[7], "R5 R6 force high", 128'({pad_out[7], pad_oe[7]}), 128'(3));

        // Random phase against the model on every clock
        for (int i = 0; i < 4000; i++) begin
            int f  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(10, 15))
                                                  : int'($urandom_range(0, 9));
            int pn = ($urandom_range(0, 9) == 0) ? int'($urandom_range(30, 31))
                                                  : int'($urandom_range(0, 29));
            step($urandom_range(0, 2) != 0, pn,
                 cfg(f, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 3))), 1'b1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule